// File: doc/BRIEF.md
# Subtract-and-Skip Single-Instruction Core

This block is a processor core with one instruction and therefore no opcode field. Every program word is an operand address. For each word the core takes the operand at that address and subtracts the accumulator from it. The difference goes into the accumulator and also back into the operand's location. If the subtraction needed a borrow, the core skips the next program word.

The core drives one single-port synchronous memory with a read latency of one cycle. Each instruction takes three memory cycles: a fetch of the program word, a read of the operand, and a write-back of the difference. The address and data width is a single parameter. A program word of all ones stops the core, and the core then raises its halt output. The memory, the program image and any program loading belong to the surrounding system.

Top module: `subskip_core`

## Requirements
- R1: While `rst_n` is low, `halt` is low. In the first cycle after reset is released the core issues a read (`mem_en`=1, `mem_we`=0) at address 0. The first difference it writes equals the operand minus zero, because reset clears the accumulator.
- R2: Each instruction starting at program counter P uses three consecutive cycles. The first reads address P. The second reads the address held in the returned word W. The third writes to W. The next fetch is issued in the cycle right after the write.
- R3: The value written in the third cycle is the operand read from W minus the accumulator, modulo 2^WORD_W.
- R4: The accumulator takes the written difference, so the next instruction subtracts that value.
- R5: A borrow occurs when the accumulator, read as an unsigned number, is greater than the operand. After a borrow the next fetch address is P+2; otherwise it is P+1. An accumulator equal to the operand gives no borrow.
- R6: The program counter wraps modulo 2^WORD_W. A skip taken at address 2^WORD_W-2 continues at address 0.
- R7: When the fetched word is all ones, the core issues no memory access in the cycle the word is returned. `halt` is high from the next cycle on.
- R8: A write is only issued in the third cycle of an instruction, to the address read in the cycle before. Two writes never occur in consecutive cycles.
- R9: Once `halt` is high it stays high and `mem_en` stays low until reset.
- R10: A reset applied in the middle of a program restarts fetching at address 0 with a cleared accumulator. Memory keeps the values it already holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | WORD_W | Memory address for this cycle |
| mem_wdata | output | WORD_W | Data to write |
| mem_we | output | 1 | Write strobe; valid only while `mem_en` is high |
| mem_en | output | 1 | Memory access request |
| mem_rdata | input | WORD_W | Read data, one cycle after the read request |
| halt | output | 1 | Core has stopped on an all-ones program word |

## Verification
Take an instruction whose fetch is issued in cycle k. The operand read for that instruction is due in cycle k+1, the write-back with its difference in k+2, and the next fetch, at P+1 or P+2, in k+3. When a stop word is fetched in cycle k, cycle k+1 must show no access and `halt` must be high from k+2. The bench steps its own model of the program one cycle at a time and samples every bus field on the falling edge of each of these cycles, so each value is compared in exactly the cycle it is due. A second instance with an 8-bit word runs far enough to cross the top of its address space with a skip.

// File: rtl/subskip_pkg.sv
// Shared types for the subtract-and-skip core.
// Assumes: the sequencer and the top module use the same state encoding.
package subskip_pkg;

    // Phases of one instruction, plus the terminal stopped phase.
    typedef enum logic [1:0] {
        SK_FETCH = 2'd0,   // read the program word at PC
        SK_OPND  = 2'd1,   // program word returned; read the operand
        SK_EXEC  = 2'd2,   // operand returned; write the difference back
        SK_HALT  = 2'd3    // stop word seen; no further accesses
    } sk_state_e;

endpackage

// File: rtl/subskip_alu.sv
// Reverse subtractor: computes operand minus accumulator and reports the borrow.
// Assumes: both inputs are unsigned words of the same width.
module subskip_alu #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] acc,
    output logic [WORD_W-1:0] diff,
    output logic              borrow
);

    localparam int EXT_W = WORD_W + 1;

    logic [EXT_W-1:0] wide;

    // Subtract with one extra bit so that the top bit carries the borrow.
    always_comb begin
        wide   = {1'b0, operand} - {1'b0, acc};
        diff   = wide[WORD_W-1:0];
        borrow = wide[WORD_W];
    end

endmodule

// File: rtl/subskip_pc.sv
// Program counter: steps by one or by two (skip) at the end of each instruction.
// Assumes: adv is high for exactly one cycle per instruction; the count wraps.
module subskip_pc #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              skip,
    output logic [WORD_W-1:0] pc
);

    localparam logic [WORD_W-1:0] STEP_ONE = WORD_W'(1);
    localparam logic [WORD_W-1:0] STEP_TWO = WORD_W'(2);

    logic [WORD_W-1:0] step;

    // Pick the step size from the borrow of the finishing instruction.
    always_comb begin
        step = skip ? STEP_TWO : STEP_ONE;
    end

    // Clear on reset; on advance add the step, wrapping at the word width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (adv) begin
            pc <= pc + step;
        end
    end

endmodule

// File: rtl/subskip_datapath.sv
// Datapath: holds the operand address and the accumulator, and runs the subtractor.
// Assumes: cap_addr is high in the cycle the program word is on rdata, and
// commit is high in the cycle the operand is on rdata.
module subskip_datapath #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_addr,
    input  logic              commit,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] op_addr,
    output logic [WORD_W-1:0] diff,
    output logic              borrow
);

    logic [WORD_W-1:0] acc_q;

    subskip_alu #(.WORD_W(WORD_W)) alu_i (
        .operand (rdata),
        .acc     (acc_q),
        .diff    (diff),
        .borrow  (borrow)
    );

    // Hold the operand address so the write-back can target it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr <= '0;
        end else if (cap_addr) begin
            op_addr <= rdata;
        end
    end

    // Accumulator: cleared on reset, loaded with each committed difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (commit) begin
            acc_q <= diff;
        end
    end

    // R8
    commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/subskip_seq.sv
// Sequencer: walks fetch, operand read and write-back, and stops on the stop word.
// Assumes: stop_word is only meaningful in the operand phase (program word on rdata).
module subskip_seq (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stop_word,
    output subskip_pkg::sk_state_e state
);
    import subskip_pkg::*;

    sk_state_e state_nx;

    // Next phase: fixed three-phase loop, left only through the stop word.
    always_comb begin
        unique case (state)
            SK_FETCH: state_nx = SK_OPND;
            SK_OPND:  state_nx = stop_word ? SK_HALT : SK_EXEC;
            SK_EXEC:  state_nx = SK_FETCH;
            default:  state_nx = SK_HALT;
        endcase
    end

    // Phase register, restarting at the fetch phase on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SK_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    // R2
    exec_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == SK_EXEC |=> state == SK_FETCH);

    // R9
    halt_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == SK_HALT |=> state == SK_HALT);

endmodule

// File: rtl/subskip_core.sv
// Subtract-and-skip core top: ties sequencer, program counter and datapath to
// one synchronous single-port memory.
// Assumes: memory read data appears one cycle after a read request; a write
// and a read are never requested in the same cycle.
module subskip_core #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_en,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halt
);
    import subskip_pkg::*;

    localparam logic [WORD_W-1:0] STOP_CODE = '1;

    sk_state_e         state;
    logic              stop_word;
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] op_addr;
    logic [WORD_W-1:0] diff;
    logic              borrow;
    logic              in_fetch;
    logic              in_opnd;
    logic              in_exec;

    // Decode the phase and recognise the stop word on the read bus.
    always_comb begin
        in_fetch  = (state == SK_FETCH);
        in_opnd   = (state == SK_OPND);
        in_exec   = (state == SK_EXEC);
        stop_word = (mem_rdata == STOP_CODE);
    end

    subskip_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_word (stop_word),
        .state     (state)
    );

    subskip_pc #(.WORD_W(WORD_W)) pc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_exec),
        .skip  (borrow),
        .pc    (pc)
    );

    subskip_datapath #(.WORD_W(WORD_W)) dp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_addr (in_opnd),
        .commit   (in_exec),
        .rdata    (mem_rdata),
        .op_addr  (op_addr),
        .diff     (diff),
        .borrow   (borrow)
    );

    // Memory port: fetch at PC, operand read at the returned word, write-back.
    always_comb begin
        mem_en    = in_fetch | (in_opnd & ~stop_word) | in_exec;
        mem_we    = in_exec;
        mem_wdata = diff;
        if (in_opnd) begin
            mem_addr = mem_rdata;
        end else if (in_exec) begin
            mem_addr = op_addr;
        end else begin
            mem_addr = pc;
        end
    end

    // Halt flag straight from the terminal phase.
    always_comb begin
        halt = (state == SK_HALT);
    end

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && !mem_en));

    // R7
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_opnd && mem_rdata == STOP_CODE) |-> (!mem_en ##1 halt));

    // R8
    write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R2
    write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en && mem_addr == $past(mem_addr) && $past(mem_en) && !$past(mem_we)));

endmodule

// File: tb/subskip_core_tb.sv
// Directed bench: a model of the program steps next to the core and checks
// every memory cycle at the falling edge.
module subskip_core_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;

    logic [15:0] a_addr, a_wdata, a_rdata;
    logic        a_we, a_en, a_halt;
    logic [7:0]  b_addr, b_wdata, b_rdata;
    logic        b_we, b_en, b_halt;

    subskip_core #(.WORD_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(a_addr), .mem_wdata(a_wdata),
        .mem_we(a_we), .mem_en(a_en), .mem_rdata(a_rdata), .halt(a_halt)
    );

    subskip_core #(.WORD_W(8)) wrap_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(b_addr), .mem_wdata(b_wdata),
        .mem_we(b_we), .mem_en(b_en), .mem_rdata(b_rdata), .halt(b_halt)
    );

    logic [15:0] mem_a [int];
    logic [15:0] mem_b [int];
    logic [15:0] ref_mem [int];

    function automatic logic [15:0] peek_a(int k);
        return mem_a.exists(k) ? mem_a[k] : 16'h0000;
    endfunction
    function automatic logic [15:0] peek_b(int k);
        return mem_b.exists(k) ? mem_b[k] : 16'h0000;
    endfunction
    function automatic logic [15:0] peek_ref(int k);
        return ref_mem.exists(k) ? ref_mem[k] : 16'h0000;
    endfunction

    // Memory models with one cycle of read latency.
    always @(posedge clk) begin
        if (a_en) begin
            if (a_we) mem_a[int'(a_addr)] = a_wdata;
            else      a_rdata <= peek_a(int'(a_addr));
        end
        if (b_en) begin
            if (b_we) mem_b[int'(b_addr)] = {8'h00, b_wdata};
            else      b_rdata <= peek_b(int'(b_addr))[7:0];
        end
    end

    int          sel = 0;
    logic [15:0] msk = 16'hFFFF;
    logic [15:0] s_addr, s_wdata;
    logic        s_en, s_we, s_halt;

    always_comb begin
        if (sel != 0) begin
            s_addr = {8'h00, b_addr}; s_wdata = {8'h00, b_wdata};
            s_en = b_en; s_we = b_we; s_halt = b_halt;
        end else begin
            s_addr = a_addr; s_wdata = a_wdata;
            s_en = a_en; s_we = a_we; s_halt = a_halt;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ld(input int a, input logic [15:0] d);
        ref_mem[a] = d & msk;
        if (sel != 0) mem_b[a] = d & msk;
        else          mem_a[a] = d & msk;
    endtask

    // Put both cores in reset and clear the selected memory and the model.
    task automatic start_test(input int s);
        @(negedge clk);
        rst_n = 1'b0;
        step_cycle();
        sel = s;
        msk = (s != 0) ? 16'h00FF : 16'hFFFF;
        chk(!s_halt, "R1 halt low in reset", {15'd0, s_halt}, 16'h0000);
        ref_mem.delete();
        if (s != 0) mem_b.delete();
        else        mem_a.delete();
    endtask

    task automatic release_rst();
        step_cycle();
        rst_n = 1'b1;
    endtask

    // Step the model and compare each bus cycle; starts at a falling edge in the fetch phase.
    task automatic run_ref(input int max_instr, output int n_exec, output int wraps, output bit halted);
        logic [15:0] pc, acc, w, op, r;
        bit b;
        bit lastb;
        pc = 16'h0; acc = 16'h0; lastb = 1'b0;
        n_exec = 0; wraps = 0; halted = 1'b0;
        for (int i = 0; i < max_instr; i++) begin
            chk(s_en && !s_we && s_addr == pc, lastb ? "R5 fetch after skip" : "R2 fetch address", s_addr, pc);
            step_cycle();
            w = peek_ref(int'(pc)) & msk;
            if (w == msk) begin
                chk(!s_en, "R7 no access on stop word", {15'd0, s_en}, 16'h0000);
                step_cycle();
                chk(s_halt, "R7 halt raised", {15'd0, s_halt}, 16'h0001);
                for (int j = 0; j < 4; j++) begin
                    step_cycle();
                    chk(s_halt && !s_en, "R9 halted and quiet", {14'd0, s_halt, s_en}, 16'h0002);
                end
                halted = 1'b1;
                return;
            end
            chk(s_en && !s_we && s_addr == w, "R2 operand read", s_addr, w);
            step_cycle();
            op = peek_ref(int'(w)) & msk;
            r  = (op - acc) & msk;
            b  = (acc > op);
            chk(s_en && s_we && s_addr == w, "R8 write target", s_addr, w);
            chk(s_wdata == r, "R3 R4 written difference", s_wdata, r);
            ref_mem[int'(w)] = r;
            acc = r;
            if (int'(pc) + 1 + int'(b) > int'(msk)) wraps++;
            pc = (pc + 16'd1 + {15'd0, b}) & msk;
            lastb = b;
            n_exec++;
            step_cycle();
        end
    endtask

    // R1: reset state and a lone stop word.
    task automatic t_reset();
        int ne, wr; bit h;
        start_test(0);
        ld(0, 16'hFFFF);
        release_rst();
        chk(!s_halt && s_en && !s_we && s_addr == 16'h0, "R1 first access reads 0", s_addr, 16'h0000);
        run_ref(5, ne, wr, h);
        chk(h, "R7 stop at address 0", {15'd0, h}, 16'h0001);
    endtask

    // R3 R4 R5: mixed borrow and no-borrow sequence ending in a stop.
    task automatic t_mixed();
        int ne, wr; bit h;
        start_test(0);
        for (int k = 0; k < 7; k++) ld(k, 16'h0100 + 16'(k));
        ld(7, 16'hFFFF);
        ld(8, 16'hFFFF);
        ld(16'h0100, 16'h0050); ld(16'h0101, 16'h0030); ld(16'h0102, 16'h8000);
        ld(16'h0103, 16'hFFF0); ld(16'h0104, 16'h0001); ld(16'h0105, 16'h7777);
        ld(16'h0106, 16'h0000);
        release_rst();
        run_ref(20, ne, wr, h);
        chk(h, "R5 mixed program halts", {15'd0, h}, 16'h0001);
    endtask

    // R5: an accumulator equal to the operand must not skip.
    task automatic t_equal();
        int ne, wr; bit h;
        start_test(0);
        ld(0, 16'h0200); ld(1, 16'h0201); ld(2, 16'h0202); ld(3, 16'hFFFF);
        ld(16'h0200, 16'h0007); ld(16'h0201, 16'h0007); ld(16'h0202, 16'h0000);
        release_rst();
        run_ref(10, ne, wr, h);
        chk(ne == 3, "R5 equal values give no skip", 16'(ne), 16'd3);
    endtask

    // R10: reset in the middle of a program restarts at 0 with a clear accumulator.
    task automatic t_midreset();
        int ne, wr; bit h;
        start_test(0);
        ld(0, 16'h0300); ld(1, 16'h0301); ld(2, 16'hFFFF); ld(3, 16'h0300); ld(4, 16'hFFFF);
        ld(16'h0300, 16'h1234); ld(16'h0301, 16'h0100);
        release_rst();
        run_ref(2, ne, wr, h);
        rst_n = 1'b0;
        step_cycle();
        step_cycle();
        rst_n = 1'b1;
        chk(s_en && !s_we && s_addr == 16'h0, "R10 restart fetch at 0", s_addr, 16'h0000);
        run_ref(10, ne, wr, h);
        chk(h, "R10 rerun reaches stop", {15'd0, h}, 16'h0001);
    endtask

    // R6: 8-bit core crosses the top of its address space with a skip.
    task automatic t_wrap();
        int ne, wr; bit h;
        start_test(1);
        for (int k = 0; k < 16'h00F0; k++) ld(k, 16'h00F0);
        for (int k = 16'h00F0; k < 16'h00FD; k++) ld(k, 16'h0000);
        ld(16'h00FD, 16'h0001);
        ld(16'h00FE, 16'h00F1);
        ld(16'h00FF, 16'h00FF);
        release_rst();
        run_ref(270, ne, wr, h);
        chk(wr >= 1, "R6 skip wrapped past the top", 16'(wr), 16'd1);
    endtask

    initial begin
        t_reset();
        t_mixed();
        t_equal();
        t_midreset();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule